// File: doc/BRIEF.md
# Framed Serial Deserializer with Lock

This block turns a serial bit stream, sampled once per rising edge of a bit-rate clock, back into 10-bit parallel words. On the wire each symbol lasts twelve bit times. A start bit of value 1 comes first, then the ten data bits with the least significant first, then an end bit of value 0. While it has no framing, the block searches the stream for a synchronisation symbol made of six ones followed by six zeros. When it finds one, it drives an active-low lock flag low and treats the next bit as a start bit.

While locked, every completed symbol places its data word on the parallel bus, together with a recovered word clock that runs at one twelfth of the bit rate. A strobe-select input decides whether downstream logic should capture on the rising or the falling edge of that clock. The data bus always changes on the opposite edge, six bit times away from the selected one. Lock is dropped after a run of consecutive symbols whose start or end bit is wrong, and the search then begins again. An output-enable input and a power-up input model high-impedance outputs through separate enable flags. Power-down also clears all framing state.

Top module: `framed_deser`

## Requirements
- R1: Within a frame, bit position 0 is the start bit and positions 1 to 10 carry data bits 0 to 9 in that order. Position 11 is the end bit. The word appears on `word_q` after the clock edge that samples the end bit.
- R2: While unlocked, `lock_n` falls on the edge that samples the last of twelve consecutive bits 111111000000 (oldest first). The bit after it is frame position 0. Lock is therefore reached one frame after the sync symbol starts, well inside 42 word periods.
- R3: `lock_n` is high after reset. It never falls on a stream that contains no sync symbol, including runs of zeros and runs of five ones followed by zeros.
- R4: Lock is lost on the end-bit edge of the fourth consecutive frame whose start bit is not 1 or whose end bit is not 0. A good frame clears the run, and a bad frame still delivers its data bits while lock holds.
- R5: `word_q` is zero while unlocked. The first selected strobe edge after lock sees zero, and the second one sees the first word received after lock.
- R6: With `strobe_rise`=1, `word_clk` goes low on the end-bit edge and high on the edge that samples frame position 5. With `strobe_rise`=0, the levels are inverted.
- R7: `data_oe` and `clk_oe` are low whenever `out_en` is low. `lock_oe` does not depend on `out_en`, and framing continues while the outputs are disabled.
- R8: With `pwr_on` low, all three enables are low at once, and after the next edge `lock_n` is high and `word_q` is zero.
- R9: A synchronous active-low `rst_n` sets `lock_n`=1, `word_q`=0 and `word_clk`=0.
- R10: A sync symbol that arrives while locked is delivered as the ordinary data word 0x01F and does not disturb framing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data bit |
| strobe_rise | input | 1 | 1: capture on rising edge of word_clk, 0: on falling edge |
| out_en | input | 1 | Output enable for data bus and word clock |
| pwr_on | input | 1 | Low powers down and clears framing |
| word_q | output | 10 | Parallel data word |
| word_clk | output | 1 | Recovered word clock |
| lock_n | output | 1 | Active-low framing lock flag |
| data_oe | output | 1 | Drive enable of word_q |
| clk_oe | output | 1 | Drive enable of word_clk |
| lock_oe | output | 1 | Drive enable of lock_n |

## Verification
The assertions assume that `ser_in`, `strobe_rise`, `out_en` and `pwr_on` are stable around each rising clock edge. The bench changes them only on the falling edge. The check that the data bus changes away from the selected strobe level also assumes that `strobe_rise` is not toggled in the middle of a frame. The bench changes it only between frames, with power on. The check that lock falls only after a sync symbol relies on a bit history that starts at reset, so the bench keeps `rst_n` low for several cycles before the first bit counts.

// File: rtl/fdes_pkg.sv
// Shared types for the framed deserializer.
package fdes_pkg;

    // Framing state: hunting for sync or tracking frames.
    typedef enum logic {
        LINK_HUNT  = 1'b0,
        LINK_TRACK = 1'b1
    } link_state_t;

    // A frame is well formed when its start bit is 1 and its end bit is 0.
    function automatic logic frame_ok(input logic start_bit, input logic end_bit);
        return start_bit & ~end_bit;
    endfunction

endpackage

// File: rtl/fdes_hunt.sv
// Sync symbol detector.
// Keeps the last FRAME_BITS-1 serial bits and raises sync_hit in the cycle
// where they, together with the current bit, form half ones then half zeros.
// Assumes bit_in is stable at the rising edge of clk.
module fdes_hunt #(
    parameter int FRAME_BITS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic bit_in,
    output logic sync_hit
);
    localparam int HALF = FRAME_BITS / 2;
    localparam logic [FRAME_BITS-1:0] SYNC_PAT =
        {{(FRAME_BITS - HALF){1'b1}}, {HALF{1'b0}}};

    logic [FRAME_BITS-2:0] hist_q;

    // Shift history of received bits, newest at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) hist_q <= '0;
        else                  hist_q <= {hist_q[FRAME_BITS-3:0], bit_in};
    end

    assign sync_hit = ({hist_q, bit_in} == SYNC_PAT);

endmodule

// File: rtl/fdes_frame.sv
// Frame tracker.
// Runs a bit-position counter over DATA_W+2 positions and collects data bits.
// It enters tracking when the hunter reports sync, checks the start and end
// bits of each frame, and drops back to hunting after LOSS_FRAMES bad frames
// in a row. Assumes sync_hit is only used while hunting.
module fdes_frame
    import fdes_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int LOSS_FRAMES = 4,
    localparam int FRAME_BITS = DATA_W + 2,
    localparam int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              bit_in,
    input  logic              sync_hit,
    output logic              locked,
    output logic              frame_end,
    output logic              drop,
    output logic [DATA_W-1:0] word,
    output logic [POS_W-1:0]  pos
);
    localparam int CNT_W = $clog2(LOSS_FRAMES + 1);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

    link_state_t       st_q;
    logic [POS_W-1:0]  pos_q;
    logic [DATA_W-1:0] data_q;
    logic              start_q;
    logic [CNT_W-1:0]  bad_q;
    logic              good;

    assign frame_end = (st_q == LINK_TRACK) && (pos_q == LAST);
    assign good      = frame_ok(start_q, bit_in);
    assign drop      = frame_end && !good && (bad_q == CNT_W'(LOSS_FRAMES - 1));
    assign locked    = (st_q == LINK_TRACK);
    assign word      = data_q;
    assign pos       = pos_q;

    // Bit position in the frame; restarts at 0 after a sync symbol.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n)                pos_q <= '0;
        else if (st_q == LINK_HUNT && sync_hit) pos_q <= '0;
        else if (pos_q == LAST)              pos_q <= '0;
        else                                 pos_q <= pos_q + POS_W'(1);
    end

    // Hunt/track state changes.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n)                   st_q <= LINK_HUNT;
        else if (st_q == LINK_HUNT && sync_hit) st_q <= LINK_TRACK;
        else if (drop)                          st_q <= LINK_HUNT;
    end

    // Store the start bit of the frame in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n)  start_q <= 1'b0;
        else if (pos_q == '0)  start_q <= bit_in;
    end

    // One capture flop per data bit, loaded at its own frame position.
    for (genvar g = 0; g < DATA_W; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n || !clr_n)             data_q[g] <= 1'b0;
            else if (pos_q == POS_W'(g + 1))  data_q[g] <= bit_in;
        end
    end

    // Count consecutive malformed frames while tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n || st_q == LINK_HUNT) bad_q <= '0;
        else if (frame_end)                         bad_q <= (good || drop) ? '0 : bad_q + CNT_W'(1);
    end

endmodule

// File: rtl/fdes_outstage.sv
// Output stage.
// Holds the parallel word and generates the recovered word clock from the
// frame position. The word changes on the end-bit edge and the clock reaches
// its selected level half a frame later. Assumes pos counts 0..FRAME_BITS-1.
module fdes_outstage #(
    parameter int DATA_W = 10,
    localparam int FRAME_BITS = DATA_W + 2,
    localparam int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              locked,
    input  logic              frame_end,
    input  logic              drop,
    input  logic [DATA_W-1:0] word_in,
    input  logic [POS_W-1:0]  pos,
    input  logic              strobe_rise,
    output logic [DATA_W-1:0] word_q,
    output logic              word_clk
);
    localparam int HALF = FRAME_BITS / 2;
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

    logic hi_next;

    assign hi_next = (pos >= POS_W'(HALF - 1)) && (pos != LAST);

    // Data word register; zero whenever framing is absent.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n || !locked) word_q <= '0;
        else if (frame_end)              word_q <= drop ? '0 : word_in;
    end

    // Word clock with the selected edge placed mid-way through each word.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) word_clk <= 1'b0;
        else                  word_clk <= strobe_rise ? hi_next : ~hi_next;
    end

endmodule

// File: rtl/framed_deser.sv
// Framed serial deserializer, top level.
// Connects the sync hunter, the frame tracker and the output stage, and
// derives the output enables. Assumes clk is already at the bit rate.
module framed_deser #(
    parameter int DATA_W      = 10,
    parameter int LOSS_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              strobe_rise,
    input  logic              out_en,
    input  logic              pwr_on,
    output logic [DATA_W-1:0] word_q,
    output logic              word_clk,
    output logic              lock_n,
    output logic              data_oe,
    output logic              clk_oe,
    output logic              lock_oe
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int POS_W      = $clog2(FRAME_BITS);

    logic              sync_hit;
    logic              locked;
    logic              frame_end;
    logic              drop;
    logic [DATA_W-1:0] word;
    logic [POS_W-1:0]  pos;

    fdes_hunt #(.FRAME_BITS(FRAME_BITS)) u_hunt (
        .clk(clk), .rst_n(rst_n), .clr_n(pwr_on),
        .bit_in(ser_in), .sync_hit(sync_hit)
    );

    fdes_frame #(.DATA_W(DATA_W), .LOSS_FRAMES(LOSS_FRAMES)) u_frame (
        .clk(clk), .rst_n(rst_n), .clr_n(pwr_on),
        .bit_in(ser_in), .sync_hit(sync_hit),
        .locked(locked), .frame_end(frame_end), .drop(drop),
        .word(word), .pos(pos)
    );

    fdes_outstage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .clr_n(pwr_on),
        .locked(locked), .frame_end(frame_end), .drop(drop),
        .word_in(word), .pos(pos), .strobe_rise(strobe_rise),
        .word_q(word_q), .word_clk(word_clk)
    );

    assign lock_n  = ~locked;
    assign lock_oe = pwr_on;
    assign data_oe = pwr_on & out_en;
    assign clk_oe  = pwr_on & out_en;

endmodule

// File: rtl/framed_deser_chk.sv
// Property checker for framed_deser, attached with bind.
// Keeps its own history of serial bits to relate lock to the sync symbol.
module framed_deser_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_in,
    input logic              strobe_rise,
    input logic              out_en,
    input logic              pwr_on,
    input logic [DATA_W-1:0] word_q,
    input logic              word_clk,
    input logic              lock_n,
    input logic              data_oe,
    input logic              clk_oe,
    input logic              lock_oe
);
    localparam int FB   = DATA_W + 2;
    localparam int HALF = FB / 2;
    localparam logic [FB-1:0] SYNC = {{(FB - HALF){1'b1}}, {HALF{1'b0}}};

    logic [FB-1:0] seen_q;

    // Independent record of the last FB bits at the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= {seen_q[FB-2:0], ser_in};
    end

    // R2: lock only follows a complete sync symbol.
    a_r2_sync_before_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> (seen_q == SYNC));

    // R5: bus is zero whenever lock is absent.
    a_r5_zero_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        lock_n |-> (word_q == '0));

    // R6: data changes only while the clock sits at its non-selected level.
    a_r6_change_off_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(word_q) && $stable(strobe_rise) && $past(pwr_on) && $past(rst_n))
        |-> (word_clk == !strobe_rise));

    // R7: disabled outputs stay off, lock drive follows power only.
    a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!data_oe && !clk_oe));

    a_r7_lock_drive: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on |-> lock_oe);

    // R8: power-down clears lock by the next edge.
    a_r8_pd_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> lock_n);

endmodule

bind framed_deser framed_deser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe_rise(strobe_rise),
    .out_en(out_en), .pwr_on(pwr_on), .word_q(word_q), .word_clk(word_clk),
    .lock_n(lock_n), .data_oe(data_oe), .clk_oe(clk_oe), .lock_oe(lock_oe)
);

// File: tb/framed_deser_bench.sv
module framed_deser_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       strobe_rise = 1'b1;
    logic       out_en = 1'b1;
    logic       pwr_on = 1'b1;
    logic [9:0] word_q;
    logic       word_clk, lock_n, data_oe, clk_oe, lock_oe;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic       mid_clk;
    logic [9:0] mid_word;

    always #4 clk = ~clk;

    framed_deser u_framed_deser (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe_rise(strobe_rise),
        .out_en(out_en), .pwr_on(pwr_on), .word_q(word_q), .word_clk(word_clk),
        .lock_n(lock_n), .data_oe(data_oe), .clk_oe(clk_oe), .lock_oe(lock_oe)
    );

    // {start, data[9:0], end, exp_lock_n, exp_word[9:0], exp_mid_word[9:0]}
    localparam int NV = 11;
    localparam logic [32:0] TBL [NV] = '{
        {1'b1, 10'h3A5, 1'b0, 1'b0, 10'h3A5, 10'h000},
        {1'b1, 10'h000, 1'b0, 1'b0, 10'h000, 10'h3A5},
        {1'b1, 10'h3FF, 1'b0, 1'b0, 10'h3FF, 10'h000},
        {1'b1, 10'h01F, 1'b0, 1'b0, 10'h01F, 10'h3FF},
        {1'b0, 10'h155, 1'b0, 1'b0, 10'h155, 10'h01F},
        {1'b1, 10'h2AA, 1'b1, 1'b0, 10'h2AA, 10'h155},
        {1'b1, 10'h0F0, 1'b0, 1'b0, 10'h0F0, 10'h2AA},
        {1'b0, 10'h111, 1'b1, 1'b0, 10'h111, 10'h0F0},
        {1'b0, 10'h222, 1'b0, 1'b0, 10'h222, 10'h111},
        {1'b1, 10'h333, 1'b1, 1'b0, 10'h333, 10'h222},
        {1'b0, 10'h044, 1'b0, 1'b1, 10'h000, 10'h333}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one bit at the falling edge; return at the next falling edge.
    task automatic step(input logic b);
        ser_in = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Send one frame; capture word_q and word_clk after frame position 5.
    task automatic send_frame(input logic s, input logic [9:0] d, input logic e);
        step(s);
        for (int i = 0; i < 10; i++) begin
            step(d[i]);
            if (i == 4) begin
                mid_clk  = word_clk;
                mid_word = word_q;
            end
        end
        step(e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step(1'b0);
        chk("R9 lock_n in reset", lock_n, 1);
        chk("R9 word_q in reset", word_q, 0);
        chk("R9 word_clk in reset", word_clk, 0);
        chk("R7 data_oe enabled", data_oe, 1);
        rst_n = 1'b1;

        // R3: zeros and near-sync patterns never lock
        repeat (20) step(1'b0);
        repeat (5) step(1'b1);
        repeat (12) step(1'b0);
        chk("R3 no lock on zeros/five ones", lock_n, 1);
        chk("R5 word zero unlocked", word_q, 0);

        // R2: sync symbol locks at its last bit
        send_frame(1'b1, 10'h01F, 1'b0);
        chk("R2 lock after sync", lock_n, 0);

        // R1 R4 R5 R6 R10: table of frames walked in order
        for (int k = 0; k < NV; k++) begin
            send_frame(TBL[k][32], TBL[k][31:22], TBL[k][21]);
            chk("R5 mid-frame strobe word", mid_word, TBL[k][9:0]);
            chk("R6 rising strobe mid-frame", mid_clk, 1);
            chk("R6 clock low at end bit", word_clk, 0);
            chk("R4 lock state", lock_n, TBL[k][20]);
            chk("R1 R10 word", word_q, TBL[k][19:10]);
        end

        // R3: unlocked, zeros keep it unlocked
        repeat (24) step(1'b0);
        chk("R3 stays unlocked", lock_n, 1);

        // R2: relock
        send_frame(1'b1, 10'h01F, 1'b0);
        chk("R2 relock", lock_n, 0);

        // R6: falling strobe inverts the clock
        strobe_rise = 1'b0;
        send_frame(1'b1, 10'h123, 1'b0);
        chk("R6 falling strobe mid-frame", mid_clk, 0);
        chk("R5 first strobe sees zero", mid_word, 0);
        chk("R6 falling strobe end bit", word_clk, 1);
        chk("R1 word falling mode", word_q, 10'h123);
        strobe_rise = 1'b1;

        // R7: output enable low
        out_en = 1'b0;
        step(1'b1);
        chk("R7 data_oe off", data_oe, 0);
        chk("R7 clk_oe off", clk_oe, 0);
        chk("R7 lock_oe stays on", lock_oe, 1);
        repeat (11) step(1'b0);
        send_frame(1'b1, 10'h0AB, 1'b0);
        chk("R7 lock tracked while disabled", lock_n, 0);
        chk("R7 word tracked while disabled", word_q, 10'h0AB);
        out_en = 1'b1;
        step(1'b1);
        chk("R7 data_oe back on", data_oe, 1);

        // R8: power-down
        pwr_on = 1'b0;
        #1;
        chk("R8 lock_oe off", lock_oe, 0);
        chk("R8 data_oe off", data_oe, 0);
        chk("R8 clk_oe off", clk_oe, 0);
        @(negedge clk);
        step(1'b0);
        chk("R8 lock cleared", lock_n, 1);
        chk("R8 word cleared", word_q, 0);
        pwr_on = 1'b1;
        repeat (12) step(1'b0);
        chk("R8 still unlocked after power-up", lock_n, 1);

        // R9: reset in the middle of lock
        send_frame(1'b1, 10'h01F, 1'b0);
        send_frame(1'b1, 10'h2C3, 1'b0);
        chk("R1 word before reset", word_q, 10'h2C3);
        rst_n = 1'b0;
        step(1'b0);
        chk("R9 lock_n after reset", lock_n, 1);
        chk("R9 word_q after reset", word_q, 0);
        chk("R9 word_clk after reset", word_clk, 0);
        rst_n = 1'b1;
        step(1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule